// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the Moore controller of a multicycle load/store processor that uses one shared memory for instructions and data and one ALU for every addition. A 4-bit state register moves through a fetch state, a decode state and then a short path chosen by the opcode. Each state drives a fixed set of datapath controls: memory read and write, the address source, instruction register load, register-file write with its destination and write-back selects, the two ALU operand selects, the ALU operation class, the PC write sources, and the writes of the exception PC and cause registers.

Loads take five cycles. Stores and register-register operations take four. Branches and jumps take three. An undefined opcode seen in decode, or an overflow reported while a register-register operation executes, sends the controller into one of two trap states. Each trap state saves the faulting PC minus 4 and a cause code, and redirects the PC to the fixed handler address. The state number is exported so that the surrounding datapath and the bench can follow the sequence.

Top module: `mcyc_sequencer`

## Requirements
- R1: While rst_n is low, state is 0 and the fetch controls are driven. Reset is asynchronous and takes effect at once, including in the middle of an instruction.
- R2: State 0 drives mem_rd=1, addr_sel=0, ir_we=1, opa_sel=0, opb_sel=01, alu_cls=00, pc_we_uncond=1 and pc_src=00. The next state is always 1.
- R3: State 1 drives opa_sel=0, opb_sel=11 and alu_cls=00. It then dispatches on the opcode: 100011 (load) and 101011 (store) go to state 2, 000000 (register op) goes to 6, 000100 (branch-equal) goes to 8, and 000010 (jump) goes to 9.
- R4: Load path. State 2 drives opa_sel=1, opb_sel=10 and alu_cls=00. State 3 drives mem_rd=1 and addr_sel=1. State 4 drives reg_we=1, wb_sel=1 and dst_sel=0. The sequence is 0,1,2,3,4,0.
- R5: Store path. The sequence is 0,1,2,5,0, and state 5 drives mem_wr=1 and addr_sel=1.
- R6: Register-op path. State 6 drives opa_sel=1, opb_sel=00 and alu_cls=10. Without overflow, the next state is 7, which drives reg_we=1, wb_sel=0 and dst_sel=1 and then returns to 0.
- R7: State 8 drives opa_sel=1, opb_sel=00, alu_cls=01, pc_we_cond=1 and pc_src=01. pc_en is high in state 8 exactly when alu_zero is high. The next state is 0.
- R8: State 9 drives pc_we_uncond=1 and pc_src=10, then returns to 0.
- R9: Any opcode other than the five listed sends state 1 to state 10. State 10 drives epc_we=1, cause_we=1, cause_ovf=0, opa_sel=0, opb_sel=01, alu_cls=01, pc_we_uncond=1 and pc_src=11, then returns to 0.
- R10: alu_ovf high in state 6 sends the next state to 11 instead of 7. State 11 drives the same controls as state 10 except cause_ovf=1, then returns to 0. alu_ovf has no effect in any other state.
- R11: Every control output not named for the current state is 0. pc_en equals pc_we_uncond OR (pc_we_cond AND alu_zero).
- R12: The state output carries the state number as a 4-bit binary value (0 through 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| alu_ovf | input | 1 | ALU signed overflow flag |
| state | output | 4 | Current state number |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU output register |
| ir_we | output | 1 | Instruction register load |
| reg_we | output | 1 | Register-file write |
| dst_sel | output | 1 | Destination register: 0 = bits 20:16, 1 = bits 15:11 |
| wb_sel | output | 1 | Write-back data: 0 = ALU output register, 1 = memory data register |
| opa_sel | output | 1 | ALU operand A: 0 = PC, 1 = A register |
| opb_sel | output | 2 | ALU operand B: 00 = B reg, 01 = 4, 10 = immediate, 11 = immediate shifted by 2 |
| alu_cls | output | 2 | ALU class: 00 add, 01 subtract, 10 use function field |
| pc_we_uncond | output | 1 | Unconditional PC write request |
| pc_we_cond | output | 1 | PC write request gated by zero |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target, 11 handler address |
| pc_en | output | 1 | Combined PC write enable |
| epc_we | output | 1 | Exception PC write |
| cause_we | output | 1 | Cause register write |
| cause_ovf | output | 1 | Cause code: 0 undefined opcode, 1 overflow |

## Verification
The hardest case to reach from the ports is the overflow trap. alu_ovf counts only in the one cycle spent in state 6, so the bench must first deliver a register-op opcode in decode and then raise the flag in exactly that cycle. Directed sequences do this, and they also hold alu_ovf high through a load and a branch to show that it is ignored there. A long random run that draws opcodes mostly from the legal set, with some arbitrary codes mixed in, and that toggles zero and overflow on every cycle, then compares the whole output vector in every state against a reference model in the bench.

// File: rtl/mcyc_pkg.sv
`timescale 1ns/1ps
package mcyc_pkg;
  localparam int ST_W  = 4;
  localparam int OP_W  = 6;
  localparam int SEL_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_LDMEM   = 4'd3,
    ST_LDWB    = 4'd4,
    ST_STMEM   = 4'd5,
    ST_ALU     = 4'd6,
    ST_ALUWB   = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9,
    ST_EXC_UND = 4'd10,
    ST_EXC_OVF = 4'd11
  } state_e;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'b000010;

  typedef struct packed {
    logic             mem_rd;
    logic             mem_wr;
    logic             addr_sel;
    logic             ir_we;
    logic             reg_we;
    logic             dst_sel;
    logic             wb_sel;
    logic             opa_sel;
    logic [SEL_W-1:0] opb_sel;
    logic [SEL_W-1:0] alu_cls;
    logic             pc_we_uncond;
    logic             pc_we_cond;
    logic [SEL_W-1:0] pc_src;
    logic             epc_we;
    logic             cause_we;
    logic             cause_ovf;
  } ctrl_t;

  function automatic logic is_legal_op(input logic [OP_W-1:0] op);
    return (op == OPC_RTYPE) || (op == OPC_LOAD) || (op == OPC_STORE) ||
           (op == OPC_BEQ) || (op == OPC_JUMP);
  endfunction

  function automatic logic pc_write_enable(input ctrl_t c, input logic zero);
    return c.pc_we_uncond | (c.pc_we_cond & zero);
  endfunction
endpackage

// File: rtl/mcyc_next_state.sv
`timescale 1ns/1ps
module mcyc_next_state
  import mcyc_pkg::*;
(
  input  state_e              cur,
  input  logic [OP_W-1:0]     opcode,
  input  logic                alu_ovf,
  output state_e              nxt
);
  state_e dispatch;

  always_comb begin
    unique case (opcode)
      OPC_LOAD, OPC_STORE: dispatch = ST_ADDR;
      OPC_RTYPE:           dispatch = ST_ALU;
      OPC_BEQ:             dispatch = ST_BRANCH;
      OPC_JUMP:            dispatch = ST_JUMP;
      default:             dispatch = ST_EXC_UND;
    endcase
  end

  always_comb begin
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = dispatch;
      ST_ADDR:   nxt = (opcode == OPC_STORE) ? ST_STMEM : ST_LDMEM;
      ST_LDMEM:  nxt = ST_LDWB;
      ST_ALU:    nxt = alu_ovf ? ST_EXC_OVF : ST_ALUWB;
      default:   nxt = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_out_decode.sv
`timescale 1ns/1ps
module mcyc_out_decode
  import mcyc_pkg::*;
(
  input  state_e cur,
  output ctrl_t  ctl
);
  always_comb begin
    ctl = '0;
    case (cur)
      ST_FETCH: begin
        ctl.mem_rd       = 1'b1;
        ctl.ir_we        = 1'b1;
        ctl.opb_sel      = 2'b01;
        ctl.pc_we_uncond = 1'b1;
      end
      ST_DECODE: ctl.opb_sel = 2'b11;
      ST_ADDR: begin
        ctl.opa_sel = 1'b1;
        ctl.opb_sel = 2'b10;
      end
      ST_LDMEM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.reg_we = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      ST_STMEM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_ALU: begin
        ctl.opa_sel = 1'b1;
        ctl.alu_cls = 2'b10;
      end
      ST_ALUWB: begin
        ctl.reg_we  = 1'b1;
        ctl.dst_sel = 1'b1;
      end
      ST_BRANCH: begin
        ctl.opa_sel    = 1'b1;
        ctl.alu_cls    = 2'b01;
        ctl.pc_we_cond = 1'b1;
        ctl.pc_src     = 2'b01;
      end
      ST_JUMP: begin
        ctl.pc_we_uncond = 1'b1;
        ctl.pc_src       = 2'b10;
      end
      ST_EXC_UND, ST_EXC_OVF: begin
        ctl.opb_sel      = 2'b01;
        ctl.alu_cls      = 2'b01;
        ctl.pc_we_uncond = 1'b1;
        ctl.pc_src       = 2'b11;
        ctl.epc_we       = 1'b1;
        ctl.cause_we     = 1'b1;
        ctl.cause_ovf    = (cur == ST_EXC_OVF);
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_sequencer.sv
`timescale 1ns/1ps
module mcyc_sequencer
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       opcode,
  input  logic             alu_zero,
  input  logic             alu_ovf,
  output logic [3:0]       state,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             addr_sel,
  output logic             ir_we,
  output logic             reg_we,
  output logic             dst_sel,
  output logic             wb_sel,
  output logic             opa_sel,
  output logic [1:0]       opb_sel,
  output logic [1:0]       alu_cls,
  output logic             pc_we_uncond,
  output logic             pc_we_cond,
  output logic [1:0]       pc_src,
  output logic             pc_en,
  output logic             epc_we,
  output logic             cause_we,
  output logic             cause_ovf
);
  state_e state_q;
  state_e state_d;
  ctrl_t  ctl;
  logic   trap_entry;   // event: next state is a trap state
  logic   done_state;   // event: current state ends an instruction

  mcyc_next_state u_next (
    .cur     (state_q),
    .opcode  (opcode),
    .alu_ovf (alu_ovf),
    .nxt     (state_d)
  );

  mcyc_out_decode u_out (
    .cur (state_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign trap_entry = (state_d == ST_EXC_UND) || (state_d == ST_EXC_OVF);
  assign done_state = (state_q == ST_LDWB) || (state_q == ST_STMEM) ||
                      (state_q == ST_ALUWB) || (state_q == ST_BRANCH) ||
                      (state_q == ST_JUMP) || (state_q == ST_EXC_UND) ||
                      (state_q == ST_EXC_OVF);

  assign state        = state_q;
  assign mem_rd       = ctl.mem_rd;
  assign mem_wr       = ctl.mem_wr;
  assign addr_sel     = ctl.addr_sel;
  assign ir_we        = ctl.ir_we;
  assign reg_we       = ctl.reg_we;
  assign dst_sel      = ctl.dst_sel;
  assign wb_sel       = ctl.wb_sel;
  assign opa_sel      = ctl.opa_sel;
  assign opb_sel      = ctl.opb_sel;
  assign alu_cls      = ctl.alu_cls;
  assign pc_we_uncond = ctl.pc_we_uncond;
  assign pc_we_cond   = ctl.pc_we_cond;
  assign pc_src       = ctl.pc_src;
  assign pc_en        = pc_write_enable(ctl, alu_zero);
  assign epc_we       = ctl.epc_we;
  assign cause_we     = ctl.cause_we;
  assign cause_ovf    = ctl.cause_ovf;

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FETCH |=> state_q == ST_DECODE);

  p_done_returns_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_state |=> state_q == ST_FETCH);

  p_branch_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BRANCH && !alu_zero) |-> !pc_en);

  p_undef_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE && !is_legal_op(opcode)) |=> state_q == ST_EXC_UND);

  p_ovf_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ALU && alu_ovf) |=> (state_q == ST_EXC_OVF && cause_ovf));

  p_trap_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_entry |=> (epc_we && cause_we && pc_en && pc_src == 2'b11));

  p_mem_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(reg_we && epc_we));
endmodule

// File: tb/mcyc_sequencer_test.sv
`timescale 1ns/1ps
module mcyc_sequencer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode;
  logic       alu_zero, alu_ovf;
  logic [3:0] state;
  logic       mem_rd, mem_wr, addr_sel, ir_we, reg_we, dst_sel, wb_sel, opa_sel;
  logic [1:0] opb_sel, alu_cls, pc_src;
  logic       pc_we_uncond, pc_we_cond, pc_en, epc_we, cause_we, cause_ovf;

  int vectors = 0;
  int fails   = 0;
  int model_s = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mcyc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
    .state(state), .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_we(ir_we),
    .reg_we(reg_we), .dst_sel(dst_sel), .wb_sel(wb_sel), .opa_sel(opa_sel),
    .opb_sel(opb_sel), .alu_cls(alu_cls), .pc_we_uncond(pc_we_uncond),
    .pc_we_cond(pc_we_cond), .pc_src(pc_src), .pc_en(pc_en), .epc_we(epc_we),
    .cause_we(cause_we), .cause_ovf(cause_ovf)
  );

  // Reference: next state from requirement text (R3..R10)
  function automatic int ref_next(int s, logic [5:0] op, logic ovf);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'b100011 || op == 6'b101011) return 2;
        if (op == 6'b000000) return 6;
        if (op == 6'b000100) return 8;
        if (op == 6'b000010) return 9;
        return 10;
      end
      2: return (op == 6'b101011) ? 5 : 3;
      3: return 4;
      6: return ovf ? 11 : 7;
      default: return 0;
    endcase
  endfunction

  // Reference: full output vector, R11 says everything unnamed is zero
  function automatic logic [23:0] ref_vec(int s, logic z);
    logic rd = 0, wr = 0, ad = 0, ir = 0, rw = 0, ds = 0, wb = 0, oa = 0;
    logic [1:0] ob = 0, ac = 0, ps = 0;
    logic pu = 0, pcnd = 0, ew = 0, cw = 0, co = 0;
    case (s)
      0: begin rd = 1; ir = 1; ob = 2'b01; pu = 1; end
      1: ob = 2'b11;
      2: begin oa = 1; ob = 2'b10; end
      3: begin rd = 1; ad = 1; end
      4: begin rw = 1; wb = 1; end
      5: begin wr = 1; ad = 1; end
      6: begin oa = 1; ac = 2'b10; end
      7: begin rw = 1; ds = 1; end
      8: begin oa = 1; ac = 2'b01; pcnd = 1; ps = 2'b01; end
      9: begin pu = 1; ps = 2'b10; end
      10, 11: begin ob = 2'b01; ac = 2'b01; pu = 1; ps = 2'b11; ew = 1; cw = 1; co = (s == 11); end
      default: ;
    endcase
    return {s[3:0], rd, wr, ad, ir, rw, ds, wb, oa, ob, ac, pu, pcnd, ps,
            (pu | (pcnd & z)), ew, cw, co};
  endfunction

  function automatic string req_of(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2, 3, 4: return "R4";
      5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      9: return "R8";
      10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag);
    logic [23:0] got, exp;
    got = {state, mem_rd, mem_wr, addr_sel, ir_we, reg_we, dst_sel, wb_sel, opa_sel,
           opb_sel, alu_cls, pc_we_uncond, pc_we_cond, pc_src, pc_en, epc_we,
           cause_we, cause_ovf};
    exp = ref_vec(model_s, alu_zero);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (R11 R12 full vector) state %0d: got %h expected %h",
               tag, model_s, got, exp);
    end
  endtask

  task automatic step(logic [5:0] op, logic z, logic v);
    @(negedge clk);
    opcode = op; alu_zero = z; alu_ovf = v;
    #1;
    check(req_of(model_s));
    model_s = ref_next(model_s, op, v);
  endtask

  task automatic run(logic [5:0] op, logic z, logic v, int n);
    for (int i = 0; i < n; i++) step(op, z, v);
  endtask

  task automatic mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_s = 0;
    check("R1");
    @(negedge clk);
    #1;
    check("R1");
    rst_n = 1'b1;
    model_s = ref_next(0, opcode, alu_ovf);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    logic [5:0] legal [5];
    legal[0] = 6'b000000; legal[1] = 6'b100011; legal[2] = 6'b101011;
    legal[3] = 6'b000100; legal[4] = 6'b000010;
    seed_dummy = $urandom(32'h5eed);
    rst_n = 1'b0; opcode = 6'b100011; alu_zero = 1'b0; alu_ovf = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    model_s = 0;
    check("R1");          // R1 reset state with fetch outputs
    rst_n = 1'b1;
    model_s = ref_next(0, opcode, alu_ovf);

    // Directed: load path with overflow held high (ignored, R10), R4
    run(6'b100011, 1'b0, 1'b1, 4);
    run(6'b100011, 1'b1, 1'b0, 5);
    // Store path R5
    run(6'b101011, 1'b0, 1'b0, 4);
    // Register op without and with overflow R6 R10
    run(6'b000000, 1'b1, 1'b0, 4);
    run(6'b000000, 1'b0, 1'b1, 4);
    // Branch taken and not taken R7, overflow ignored
    run(6'b000100, 1'b1, 1'b1, 3);
    run(6'b000100, 1'b0, 1'b1, 3);
    // Jump R8
    run(6'b000010, 1'b0, 1'b0, 3);
    // Undefined opcodes R9
    run(6'b111111, 1'b0, 1'b0, 3);
    run(6'b000001, 1'b1, 1'b1, 3);
    // Reset in the middle of a load R1
    run(6'b100011, 1'b0, 1'b0, 4);
    mid_reset();

    for (int i = 0; i < 4000; i++) begin
      logic [5:0] op;
      if ($urandom_range(0, 7) == 0) op = 6'($urandom);
      else op = legal[$urandom_range(0, 4)];
      step(op, 1'($urandom), 1'($urandom_range(0, 3) == 0));
      if (i == 2500) mid_reset();
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule